// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block chooses which of five interrupt sources a processor should service next. The sources are external 0, timer 0, external 1, timer 1 and a serial port. The serial port raises a request when either its receive flag or its transmit flag is set. Software controls the arbiter through two registers. The enable register holds a global switch and one bit per source. The priority register places each source in either the high level or the low level. Inside a level, the sources are ranked in a fixed order.

Time advances in machine cycles, and each machine cycle is marked by a clock-enable strobe. In every machine cycle the arbiter captures a snapshot of the request flags. In the next machine cycle it polls that snapshot. A poll can be suppressed in three cases: the current instruction is not in its last cycle, a return-from-interrupt is executing, or one of the two registers is being written. Nothing is remembered from a poll that loses. When a poll wins, the arbiter sends a one-clock vector request, a 16-bit service address, and a one-hot clear pulse to the source whose flag hardware should drop. Two in-service bits, one per level, record which service routines are active. A return pulse releases the high level first and the low level only when the high level is idle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every priority bit and both in-service bits are 0. No vector is issued, even when all flags are held high.
- R2: A source can win only when its own enable bit and the global enable bit 7 are both 1. The enable bit positions are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R3: Within one level, a lower source index beats a higher one (external 0 > timer 0 > external 1 > timer 1 > serial). The address for source index i is 0x0003 + 8*i.
- R4: The priority register uses the same bit positions as the enable register, and a 1 puts the source in the high level. Any eligible high-level source beats every low-level source.
- R5: `in_svc[1]` marks the high level in service and `in_svc[0]` the low level. While the low level is in service, only high-level requests can win. While the high level is in service, nothing can win. A win sets the bit of its own level.
- R6: A return pulse in a machine cycle clears `in_svc[1]` when it is set, and otherwise clears `in_svc[0]`.
- R7: No vector is issued from a poll taken while `instr_last` is 0, `reti` is 1, or a register write strobe is 1. When the block ends and the request is still present, the vector follows on the next poll.
- R8: Flags captured in one machine cycle are polled in the next one. A request that has dropped by the time blocking ends is never serviced.
- R9: `src_ack` is one-hot and pulses together with `vec_req`. It is always set for a timer winner, set for an external winner only when that input's `ext_edge` bit is 1, and never set for serial. The serial request is `ser_rx | ser_tx`.
- R10: `vec_req` is a single-clock pulse, registered on the clock edge that ends the winning poll cycle. Captures, polls, writes and returns take effect only in clock cycles where `cyc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe; qualifies every other input |
| instr_last | input | 1 | Current cycle is the last cycle of the instruction |
| reti | input | 1 | Return-from-interrupt in progress (release pulse) |
| en_wr | input | 1 | Write strobe for the enable register |
| pri_wr | input | 1 | Write strobe for the priority register |
| wr_data | input | 8 | Register write data |
| flag_in | input | 4 | Request flags: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| ext_edge | input | 2 | Edge mode for external 0 (bit 0) and external 1 (bit 1) |
| vec_req | output | 1 | One-clock vector request |
| vec_addr | output | 16 | Service address of the last winner |
| src_ack | output | 5 | One-hot flag-clear pulse, indexed like the enable bits |
| in_svc | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The assertions assume that `reti` arrives only while some level is in service, and only in a cycle where `cyc_en` is 1. They also assume that inputs change only between clock edges. The bench drives every input on the falling edge. It issues a return only after it has seen a vector, so the number of returns never exceeds the number of active levels. It takes a flag down as soon as a vector has been observed, in the same way a source would respond to its clear pulse. Register writes are made only while all flags are low, unless a test is checking that a write blocks a poll.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned NLVL  = 2;

  localparam int unsigned SRC_EXT0 = 0;
  localparam int unsigned SRC_TMR0 = 1;
  localparam int unsigned SRC_EXT1 = 2;
  localparam int unsigned SRC_TMR1 = 3;
  localparam int unsigned SRC_SER  = 4;

  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [IDX_W-1:0] src_idx_t;
  typedef logic [NLVL-1:0]  lvl_vec_t;

  localparam src_vec_t TIMER_SRCS = src_vec_t'((1 << SRC_TMR0) | (1 << SRC_TMR1));
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int unsigned REG_W      = 8,
  parameter int unsigned GLOBAL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             en_wr,
  input  logic             pri_wr,
  input  logic [REG_W-1:0] wr_data,
  output src_vec_t         src_en,
  output src_vec_t         src_hi
);
  logic     glob_q, glob_d;
  src_vec_t en_q, en_d;
  src_vec_t pri_q, pri_d;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^wr_data[GLOBAL_BIT-1:NSRC];

  always_comb begin
    glob_d = glob_q;
    en_d   = en_q;
    pri_d  = pri_q;
    if (cyc_en && en_wr) begin
      glob_d = wr_data[GLOBAL_BIT];
      en_d   = wr_data[NSRC-1:0];
    end
    if (cyc_en && pri_wr) begin
      pri_d = wr_data[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
    end else begin
      glob_q <= glob_d;
      en_q   <= en_d;
      pri_q  <= pri_d;
    end
  end

  assign src_en = en_q & {NSRC{glob_q}};
  assign src_hi = pri_q;

  // R2: a write with the global bit clear leaves no source enabled
  p_global_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && en_wr && !wr_data[GLOBAL_BIT]) |=> (src_en == '0));
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
(
  input  src_vec_t cand,
  output logic     any,
  output src_idx_t idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = src_idx_t'(i);
    end
  end
endmodule

// File: rtl/prio_irq_svc.sv
module prio_irq_svc
  import prio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cyc_en,
  input  logic     reti,
  input  logic     grant,
  input  logic     grant_hi,
  output lvl_vec_t svc
);
  lvl_vec_t svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (cyc_en) begin
      if (reti) begin
        if (svc_q[LVL_HI]) svc_d[LVL_HI] = 1'b0;
        else               svc_d[LVL_LO] = 1'b0;
      end else if (grant) begin
        if (grant_hi) svc_d[LVL_HI] = 1'b1;
        else          svc_d[LVL_LO] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign svc = svc_q;

  // R6: release of the high level leaves the low level untouched
  p_reti_hi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && reti && svc_q[LVL_HI]) |=> (!svc_q[LVL_HI] && (svc_q[LVL_LO] == $past(svc_q[LVL_LO]))));

  // R6: release with the high level idle drops the low level
  p_reti_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && reti && !svc_q[LVL_HI]) |=> !svc_q[LVL_LO]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned REG_W      = 8,
  parameter int unsigned GLOBAL_BIT = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              instr_last,
  input  logic              reti,
  input  logic              en_wr,
  input  logic              pri_wr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NSRC-2:0]   flag_in,
  input  logic              ser_rx,
  input  logic              ser_tx,
  input  logic [1:0]        ext_edge,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [NSRC-1:0]   src_ack,
  output logic [NLVL-1:0]   in_svc
);
  src_vec_t raw_req, snap_q, snap_d;
  src_vec_t src_en, src_hi, elig;
  src_vec_t cand [NLVL];
  logic     lvl_any [NLVL];
  src_idx_t lvl_idx [NLVL];
  lvl_vec_t svc;
  logic     poll_ok, take_hi, take_lo, grant;
  src_idx_t gidx;
  src_vec_t clr_ok, gsel;

  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  src_vec_t          ack_q, ack_d;

  prio_irq_cfg #(.REG_W(REG_W), .GLOBAL_BIT(GLOBAL_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .en_wr(en_wr), .pri_wr(pri_wr),
    .wr_data(wr_data), .src_en(src_en), .src_hi(src_hi)
  );

  // flag snapshot, one per machine cycle
  assign raw_req = {ser_rx | ser_tx, flag_in};

  always_comb begin
    snap_d = snap_q;
    if (cyc_en) snap_d = raw_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // per-level candidate selection
  assign elig         = snap_q & src_en;
  assign cand[LVL_HI] = elig & src_hi;
  assign cand[LVL_LO] = elig & ~src_hi;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    prio_irq_pick u_pick (
      .cand(cand[g]), .any(lvl_any[g]), .idx(lvl_idx[g])
    );
  end

  prio_irq_svc u_svc (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .reti(reti),
    .grant(grant), .grant_hi(take_hi), .svc(svc)
  );

  // poll decision
  assign poll_ok = cyc_en && instr_last && !reti && !en_wr && !pri_wr && !svc[LVL_HI];
  assign take_hi = poll_ok && lvl_any[LVL_HI];
  assign take_lo = poll_ok && !lvl_any[LVL_HI] && lvl_any[LVL_LO] && !svc[LVL_LO];
  assign grant   = take_hi || take_lo;
  assign gidx    = take_hi ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
  assign gsel    = src_vec_t'(1) << gidx;

  always_comb begin
    clr_ok           = TIMER_SRCS;
    clr_ok[SRC_EXT0] = ext_edge[0];
    clr_ok[SRC_EXT1] = ext_edge[1];
  end

  always_comb begin
    req_d  = grant;
    addr_d = addr_q;
    ack_d  = '0;
    if (grant) begin
      addr_d = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(gidx));
      ack_d  = gsel & clr_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      ack_q  <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      ack_q  <= ack_d;
    end
  end

  assign vec_req  = req_q;
  assign vec_addr = addr_q;
  assign src_ack  = ack_q;
  assign in_svc   = svc;

  // R7: a vector only follows an unblocked poll cycle
  p_unblocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(instr_last && !reti && !en_wr && !pri_wr));

  // R5: no vector while the high level was in service
  p_hi_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(in_svc[LVL_HI]));

  // R5: every vector leaves some level marked in service
  p_svc_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (in_svc != '0));

  // R9: clear pulse is one-hot, rides on the vector, never hits serial
  p_ack_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack) && ((src_ack == '0) || vec_req) && !src_ack[SRC_SER]);

  // R10: vectors only come from machine cycles
  p_cycle_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(cyc_en));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b1;
  logic        instr_last = 1'b1;
  logic        reti = 1'b0;
  logic        en_wr = 1'b0;
  logic        pri_wr = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [3:0]  flag_in = 4'hF;
  logic        ser_rx = 1'b1;
  logic        ser_tx = 1'b0;
  logic [1:0]  ext_edge = 2'b00;
  logic        vec_req;
  logic [15:0] vec_addr;
  logic [4:0]  src_ack;
  logic [1:0]  in_svc;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] en_m = 8'h00;
  logic [7:0] pri_m = 8'h00;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .instr_last(instr_last), .reti(reti),
    .en_wr(en_wr), .pri_wr(pri_wr), .wr_data(wr_data), .flag_in(flag_in),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .ext_edge(ext_edge),
    .vec_req(vec_req), .vec_addr(vec_addr), .src_ack(src_ack), .in_svc(in_svc)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] d);
    @(negedge clk); en_wr = 1'b1; wr_data = d;
    @(negedge clk); en_wr = 1'b0; en_m = d;
  endtask

  task automatic wr_pri(input logic [7:0] d);
    @(negedge clk); pri_wr = 1'b1; wr_data = d;
    @(negedge clk); pri_wr = 1'b0; pri_m = d;
  endtask

  task automatic ret_pulse();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic set_flags(input logic [4:0] f, input bit rx_only);
    flag_in = f[3:0];
    ser_rx  = f[4] && (rx_only || f[0]);
    ser_tx  = f[4] && !(rx_only && !f[0]);
  endtask

  // one scenario from an idle state; expected result computed from R2..R5, R9
  task automatic run_case(input logic [4:0] f, input bit rx_only,
                          input logic [1:0] edg, input string rq);
    logic [4:0]  elig, hi, lo, cand, ack_e;
    logic        g;
    int          idx;
    logic [1:0]  svc_e;
    logic [15:0] addr_e;
    elig  = f & en_m[4:0] & {5{en_m[7]}};
    hi    = elig & pri_m[4:0];
    lo    = elig & ~pri_m[4:0];
    cand  = (hi != 0) ? hi : lo;
    g     = (cand != 0);
    idx   = 0;
    for (int i = 4; i >= 0; i--) if (cand[i]) idx = i;
    addr_e = 16'(3 + 8 * idx);
    ack_e  = 5'b0;
    if (g) begin
      if (idx == 1 || idx == 3) ack_e = 5'(1 << idx);
      if (idx == 0 && edg[0])   ack_e = 5'b00001;
      if (idx == 2 && edg[1])   ack_e = 5'b00100;
    end
    svc_e = !g ? 2'b00 : ((hi != 0) ? 2'b10 : 2'b01);
    @(negedge clk);
    set_flags(f, rx_only);
    ext_edge = edg;
    step(2);
    chk(vec_req == g, rq, "vec_req", 32'(vec_req), 32'(g));
    if (g) chk(vec_addr == addr_e, rq, "vec_addr", 32'(vec_addr), 32'(addr_e));
    chk({src_ack, in_svc} == {ack_e, svc_e}, rq, "ack/svc",
        32'({src_ack, in_svc}), 32'({ack_e, svc_e}));
    set_flags(5'b0, 1'b0);
    if (g) ret_pulse();
    step(2);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state with every flag held high
    step(3);
    chk({vec_req, src_ack, in_svc} == 8'h00, "R1", "in reset", 32'({vec_req, src_ack, in_svc}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(vec_req == 1'b0, "R1", "enables clear after reset", 32'(vec_req), 0);
    end
    chk(in_svc == 2'b00, "R1", "in_svc after reset", 32'(in_svc), 0);
    set_flags(5'b0, 1'b0);
    step(2);

    // R2: sweep over the enable register, global bit on and off, all flags up
    for (int e = 0; e < 64; e++) begin
      wr_en({e[5], 2'b00, 5'(e)});
      run_case(5'h1F, e[0], 2'(e), "R2");
    end

    // R3/R4/R9: every flag pattern against every priority pattern
    wr_en(8'h9F);
    for (int p = 0; p < 32; p++) begin
      wr_pri(8'(p));
      for (int f = 0; f < 32; f++) begin
        run_case(5'(f), f[1], 2'(f ^ p), (p == 0) ? "R3" : ((f[4]) ? "R9" : "R4"));
      end
    end

    // R5/R6/R8: nesting with ext0 and tmr1 high, others low
    wr_pri(8'h09);
    ext_edge = 2'b01;
    @(negedge clk); set_flags(5'b00010, 1'b0);
    step(2);
    chk(vec_req && vec_addr == 16'h000B && in_svc == 2'b01 && src_ack == 5'b00010, "R5",
        "low vector", 32'({vec_addr, src_ack, in_svc}), 32'({16'h000B, 5'b00010, 2'b01}));
    set_flags(5'b00100, 1'b0);
    step(3);
    chk(vec_req == 1'b0 && in_svc == 2'b01, "R5", "low blocks low",
        32'({vec_req, in_svc}), 32'({1'b0, 2'b01}));
    set_flags(5'b00101, 1'b0);
    step(2);
    chk(vec_req && vec_addr == 16'h0003 && in_svc == 2'b11 && src_ack == 5'b00001, "R5",
        "high preempts low", 32'({vec_addr, src_ack, in_svc}), 32'({16'h0003, 5'b00001, 2'b11}));
    set_flags(5'b01100, 1'b0);
    step(3);
    chk(vec_req == 1'b0 && in_svc == 2'b11, "R5", "high blocks high",
        32'({vec_req, in_svc}), 32'({1'b0, 2'b11}));
    set_flags(5'b00100, 1'b0);
    reti = 1'b1;
    step(1);
    reti = 1'b0;
    chk(in_svc == 2'b01 && !vec_req, "R6", "release high first", 32'(in_svc), 32'(2'b01));
    reti = 1'b1;
    step(1);
    reti = 1'b0;
    chk(in_svc == 2'b00 && !vec_req, "R6", "release low", 32'(in_svc), 0);
    step(1);
    chk(vec_req && vec_addr == 16'h0013 && src_ack == 5'b0, "R8", "pending low after release",
        32'({vec_addr, src_ack}), 32'({16'h0013, 5'b0}));
    set_flags(5'b0, 1'b0);
    ret_pulse();
    wr_pri(8'h00);

    // R7: three kinds of block, each delaying a timer 1 vector by one poll
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); set_flags(5'b01000, 1'b0);
      step(1);
      if (k == 0) instr_last = 1'b0;
      if (k == 1) reti = 1'b1;
      if (k == 2) begin en_wr = 1'b1; wr_data = 8'h9F; end
      step(1);
      instr_last = 1'b1; reti = 1'b0; en_wr = 1'b0;
      chk(vec_req == 1'b0, "R7", "blocked poll", 32'(vec_req), 0);
      step(1);
      chk(vec_req && vec_addr == 16'h001B && src_ack == 5'b01000, "R7", "vector after block",
          32'({vec_req, vec_addr}), 32'({1'b1, 16'h001B}));
      set_flags(5'b0, 1'b0);
      ret_pulse();
      step(1);
    end

    // R8: request dropped while blocked is never serviced
    @(negedge clk); set_flags(5'b00001, 1'b0); instr_last = 1'b0;
    step(3);
    chk(vec_req == 1'b0, "R8", "held off", 32'(vec_req), 0);
    set_flags(5'b0, 1'b0);
    step(1);
    instr_last = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk(vec_req == 1'b0 && in_svc == 2'b00, "R8", "no memory of denied request",
          32'({vec_req, in_svc}), 0);
    end

    // R10: machine-cycle gating and single-clock pulse
    @(negedge clk); cyc_en = 1'b0; set_flags(5'b00010, 1'b0);
    step(4);
    chk(vec_req == 1'b0 && in_svc == 2'b00, "R10", "idle without cyc_en", 32'(vec_req), 0);
    cyc_en = 1'b1;
    step(2);
    chk(vec_req && vec_addr == 16'h000B, "R10", "vector after two strobes",
        32'({vec_req, vec_addr}), 32'({1'b1, 16'h000B}));
    set_flags(5'b0, 1'b0);
    step(1);
    chk(vec_req == 1'b0 && src_ack == 5'b0, "R10", "pulse is one clock",
        32'({vec_req, src_ack}), 0);
    ret_pulse();
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule